// File: doc/BRIEF.md
# Linked-Descriptor Peripheral DMA Engine

This engine moves 32-bit words between a peripheral FIFO and system memory. It does not take a single address and length. It walks a chain of descriptors held in memory. Each descriptor occupies four words: a flags/count word, a buffer address, the address of the next descriptor, and a reserved word. For each descriptor the engine moves the requested bytes one word per beat, in the direction selected by software. It then follows the branch address, and it stops after the descriptor whose end flag is set.

Software programs a small register file through a word-indexed write/read port. The registers are a global control word (enable, soft reset and FIFO stall limit), an interrupt enable, a write-one-to-clear interrupt status, the chain's first descriptor address, and a channel word. The channel word holds the run bit and the direction, and it reports a 4-bit completion code. Every way the walk can end (success, FIFO starvation, FIFO congestion, a failed descriptor fetch, a failed data beat, or an early end from the peripheral) has its own code. Each of them also sets the interrupt status.

Top module: `chain_dma`

## Requirements
- R1: After reset every register reads zero, `irq` is low and no memory request is made.
- R2: A descriptor at address D is fetched by reading D, D+4 and D+8. In the first word, bits [15:0] give the byte count, bit 30 is a format bit that must be 1, and bit 31 marks the last descriptor. The count is moved as ceil(count/4) word beats at successive buffer words.
- R3: With channel bit 22 set (peripheral to memory), each word popped from the FIFO is written to the next buffer word, in FIFO order.
- R4: With channel bit 22 clear (memory to peripheral), buffer words are read in order and pushed to the FIFO in that order.
- R5: When a descriptor with bit 31 clear finishes, the next fetch uses its branch word. When a descriptor with bit 31 set finishes, the channel code (bits [3:0], register index 4) becomes 15, the run bit (bit 7) clears and interrupt status bit 0 sets.
- R6: A descriptor with a byte count of zero moves no data, and the chain continues past it.
- R7: If the FIFO stays empty (peripheral to memory) or full (memory to peripheral) for more consecutive cycles than the limit in global control bits [23:16], the walk stops with code 1 or code 2 respectively.
- R8: An error response to a descriptor fetch, or a descriptor whose format bit is 0, stops the walk with code 3 and moves no data for that descriptor.
- R9: An error response to a data beat stops the walk with code 4.
- R10: If the peripheral raises its end signal while the engine waits on the FIFO, the walk stops with code 5. This takes priority over a handshake in the same cycle.
- R11: `irq` equals interrupt status bit 0 AND interrupt enable bit 0 (index 1). Writing 1 to status bit 0 (index 2) clears it, and writing 0 has no effect.
- R12: Writing global control (index 0) with bit 8 set returns the engine to idle and clears both the enable (bit 0) and the run bit. From the next cycle on, no memory or FIFO transfer occurs.
- R13: A walk starts only when the enable and the run bit are both set. A memory request holds its address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index: 0 global, 1 irq enable, 2 irq status, 3 descriptor pointer, 4 channel |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the register at `regAddr` (combinational) |
| memReq | output | 1 | Memory request, held until `memAck` |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | AW | Byte address of the word |
| memWData | output | 32 | Write data |
| memAck | input | 1 | Request completes this cycle |
| memErr | input | 1 | Error response, valid with `memAck` |
| memRData | input | 32 | Read data, valid with `memAck` |
| perValid | input | 1 | FIFO holds a word for the engine |
| perRdData | input | 32 | FIFO head word |
| perPop | output | 1 | Engine takes the head word |
| perReady | input | 1 | FIFO has room |
| perPush | output | 1 | Engine pushes `perWrData` |
| perWrData | output | 32 | Word pushed to the FIFO |
| perEnd | input | 1 | Peripheral ends the transfer early |
| irq | output | 1 | Interrupt |

## Verification
The checker watches, on every cycle, the handshake rules that hold whatever the chain looks like. A pending memory request keeps its address and direction until it is acknowledged. A FIFO pop or push happens only when the FIFO permits it, and never together with a memory request. A soft reset silences both ports from the next cycle. Only the bench's scenarios can show that words land in the right buffer slots across a chain of random counts, including zero counts. They also show that each error source reports its own completion code, and that the interrupt follows its enable and clear rules.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_PERX,
    ST_MEMX,
    ST_NEXT
  } dmaState_e;

  localparam logic [3:0] EV_NONE  = 4'd0;
  localparam logic [3:0] EV_UNDER = 4'd1;
  localparam logic [3:0] EV_OVER  = 4'd2;
  localparam logic [3:0] EV_DESC  = 4'd3;
  localparam logic [3:0] EV_DATA  = 4'd4;
  localparam logic [3:0] EV_EARLY = 4'd5;
  localparam logic [3:0] EV_OK    = 4'd15;

  localparam logic [2:0] REG_GCTL  = 3'd0;
  localparam logic [2:0] REG_IEN   = 3'd1;
  localparam logic [2:0] REG_ISTAT = 3'd2;
  localparam logic [2:0] REG_DPTR  = 3'd3;
  localparam logic [2:0] REG_CHAN  = 3'd4;

  // control -> datapath strobes
  typedef struct packed {
    logic       busy;
    logic       startWalk;
    logic       capWord;
    logic       loadBranch;
    logic       capData;
    logic       beatDone;
    logic       stallInc;
    logic       addrDesc;
    logic       finish;
    logic [3:0] finCode;
  } dmaStrobe_t;

endpackage

// File: rtl/chain_dma_dpath.sv
module chain_dma_dpath
  import chain_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  dmaStrobe_t       stb,
  input  logic [31:0]      memRData,
  input  logic [31:0]      perRdData,
  output logic [AW-1:0]    memAddr,
  output logic [31:0]      memWData,
  output logic [31:0]      perWrData,
  output logic             irq,
  output logic             enable,
  output logic             run,
  output logic             dir,
  output logic             softRst,
  output logic             lastWord,
  output logic             remZero,
  output logic             remLast,
  output logic             isLast,
  output logic             formatOk,
  output logic             stallHit
);

  localparam int WRD_W = CNT_W - 1;

  logic              enableR, ienR, isrR, runR, dirR;
  logic [3:0]        codeR;
  logic [LIM_W-1:0]  stallLimR, stallCnt;
  logic [AW-1:0]     descPtrR, curDesc, bufAddr, branchR;
  logic [1:0]        fIdx;
  logic [WRD_W-1:0]  remWords;
  logic              lastR, fmtR;
  logic [31:0]       dataR;
  logic [CNT_W:0]    cntRound;

  logic wrGctl, wrIen, wrIstat, wrDptr, wrChan;

  assign wrGctl  = regWrEn && (regAddr == REG_GCTL);
  assign wrIen   = regWrEn && (regAddr == REG_IEN);
  assign wrIstat = regWrEn && (regAddr == REG_ISTAT);
  assign wrDptr  = regWrEn && (regAddr == REG_DPTR);
  assign wrChan  = regWrEn && (regAddr == REG_CHAN);
  assign softRst = wrGctl && regWrData[8];

  // software-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableR   <= 1'b0;
      stallLimR <= '0;
      ienR      <= 1'b0;
      isrR      <= 1'b0;
      descPtrR  <= '0;
      runR      <= 1'b0;
      dirR      <= 1'b0;
      codeR     <= EV_NONE;
    end else begin
      if (wrGctl) begin
        enableR   <= regWrData[0] & ~regWrData[8];
        stallLimR <= regWrData[16 +: LIM_W];
      end
      if (wrIen)  ienR     <= regWrData[0];
      if (wrDptr) descPtrR <= regWrData[AW-1:0];
      if (stb.finish)                   isrR <= 1'b1;
      else if (wrIstat && regWrData[0]) isrR <= 1'b0;
      if (softRst) begin
        runR <= 1'b0;
      end else if (stb.finish) begin
        runR  <= 1'b0;
        codeR <= stb.finCode;
      end else if (wrChan && !stb.busy) begin
        runR  <= regWrData[7];
        dirR  <= regWrData[22];
        codeR <= EV_NONE;
      end
    end
  end

  assign cntRound = {1'b0, memRData[CNT_W-1:0]} + (CNT_W+1)'(3);

  // walk state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curDesc  <= '0;
      bufAddr  <= '0;
      branchR  <= '0;
      fIdx     <= '0;
      remWords <= '0;
      lastR    <= 1'b0;
      fmtR     <= 1'b0;
      dataR    <= '0;
      stallCnt <= '0;
    end else begin
      if (stb.startWalk) begin
        curDesc <= descPtrR;
        fIdx    <= '0;
      end else if (stb.loadBranch) begin
        curDesc <= branchR;
        fIdx    <= '0;
      end else if (stb.capWord) begin
        fIdx <= fIdx + 2'd1;
        case (fIdx)
          2'd0: begin
            remWords <= cntRound[CNT_W:2];
            fmtR     <= memRData[30];
            lastR    <= memRData[31];
          end
          2'd1:    bufAddr <= memRData[AW-1:0];
          default: branchR <= memRData[AW-1:0];
        endcase
      end
      if (stb.capData) dataR <= dirR ? perRdData : memRData;
      if (stb.beatDone) begin
        bufAddr  <= bufAddr + AW'(4);
        remWords <= remWords - WRD_W'(1);
      end
      stallCnt <= stb.stallInc ? stallCnt + LIM_W'(1) : '0;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_GCTL: begin
        regRdData[0]            = enableR;
        regRdData[16 +: LIM_W]  = stallLimR;
      end
      REG_IEN:   regRdData[0] = ienR;
      REG_ISTAT: regRdData[0] = isrR;
      REG_DPTR:  regRdData[AW-1:0] = descPtrR;
      REG_CHAN: begin
        regRdData[3:0] = codeR;
        regRdData[7]   = runR;
        regRdData[22]  = dirR;
      end
      default: ;
    endcase
  end

  assign memAddr   = stb.addrDesc ? (curDesc + AW'({fIdx, 2'b00})) : bufAddr;
  assign memWData  = dataR;
  assign perWrData = dataR;
  assign irq       = isrR & ienR;

  assign enable   = enableR;
  assign run      = runR;
  assign dir      = dirR;
  assign lastWord = (fIdx == 2'd2);
  assign remZero  = (remWords == '0);
  assign remLast  = (remWords == WRD_W'(1));
  assign isLast   = lastR;
  assign formatOk = fmtR;
  assign stallHit = (stallCnt == stallLimR);

  logic unusedBits;
  assign unusedBits = ^{regWrData, memRData};

endmodule

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
  import chain_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       run,
  input  logic       dir,
  input  logic       softRst,
  input  logic       lastWord,
  input  logic       remZero,
  input  logic       remLast,
  input  logic       isLast,
  input  logic       formatOk,
  input  logic       stallHit,
  input  logic       memAck,
  input  logic       memErr,
  input  logic       perValid,
  input  logic       perReady,
  input  logic       perEnd,
  output dmaStrobe_t stb,
  output logic       memReq,
  output logic       memWe,
  output logic       perPop,
  output logic       perPush
);

  dmaState_e st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    stb      = '0;
    stb.busy = (st != ST_IDLE);
    nxt      = st;
    memReq   = 1'b0;
    memWe    = 1'b0;
    perPop   = 1'b0;
    perPush  = 1'b0;
    if (softRst) begin
      nxt = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (enable && run) begin
            stb.startWalk = 1'b1;
            nxt           = ST_FETCH;
          end
        end
        ST_FETCH: begin
          memReq       = 1'b1;
          stb.addrDesc = 1'b1;
          if (memAck) begin
            if (memErr) begin
              stb.finish  = 1'b1;
              stb.finCode = EV_DESC;
              nxt         = ST_IDLE;
            end else begin
              stb.capWord = 1'b1;
              if (lastWord) begin
                if (!formatOk) begin
                  stb.finish  = 1'b1;
                  stb.finCode = EV_DESC;
                  nxt         = ST_IDLE;
                end else if (remZero) nxt = ST_NEXT;
                else if (dir)         nxt = ST_PERX;
                else                  nxt = ST_MEMX;
              end
            end
          end
        end
        ST_PERX: begin
          if (perEnd) begin
            stb.finish  = 1'b1;
            stb.finCode = EV_EARLY;
            nxt         = ST_IDLE;
          end else if (dir) begin
            if (perValid) begin
              perPop      = 1'b1;
              stb.capData = 1'b1;
              nxt         = ST_MEMX;
            end else if (stallHit) begin
              stb.finish  = 1'b1;
              stb.finCode = EV_UNDER;
              nxt         = ST_IDLE;
            end else begin
              stb.stallInc = 1'b1;
            end
          end else begin
            if (perReady) begin
              perPush      = 1'b1;
              stb.beatDone = 1'b1;
              nxt          = remLast ? ST_NEXT : ST_MEMX;
            end else if (stallHit) begin
              stb.finish  = 1'b1;
              stb.finCode = EV_OVER;
              nxt         = ST_IDLE;
            end else begin
              stb.stallInc = 1'b1;
            end
          end
        end
        ST_MEMX: begin
          memReq = 1'b1;
          memWe  = dir;
          if (memAck) begin
            if (memErr) begin
              stb.finish  = 1'b1;
              stb.finCode = EV_DATA;
              nxt         = ST_IDLE;
            end else if (dir) begin
              stb.beatDone = 1'b1;
              nxt          = remLast ? ST_NEXT : ST_PERX;
            end else begin
              stb.capData = 1'b1;
              nxt         = ST_PERX;
            end
          end
        end
        ST_NEXT: begin
          if (isLast) begin
            stb.finish  = 1'b1;
            stb.finCode = EV_OK;
            nxt         = ST_IDLE;
          end else begin
            stb.loadBranch = 1'b1;
            nxt            = ST_FETCH;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16,
  parameter int LIM_W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [2:0]    regAddr,
  input  logic [31:0]   regWrData,
  output logic [31:0]   regRdData,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWData,
  input  logic          memAck,
  input  logic          memErr,
  input  logic [31:0]   memRData,
  input  logic          perValid,
  input  logic [31:0]   perRdData,
  output logic          perPop,
  input  logic          perReady,
  output logic          perPush,
  output logic [31:0]   perWrData,
  input  logic          perEnd,
  output logic          irq
);

  dmaStrobe_t stb;
  logic enable, run, dir, softRst, lastWord, remZero, remLast, isLast, formatOk, stallHit;

  chain_dma_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .enable(enable), .run(run), .dir(dir), .softRst(softRst),
    .lastWord(lastWord), .remZero(remZero), .remLast(remLast),
    .isLast(isLast), .formatOk(formatOk), .stallHit(stallHit),
    .memAck(memAck), .memErr(memErr),
    .perValid(perValid), .perReady(perReady), .perEnd(perEnd),
    .stb(stb), .memReq(memReq), .memWe(memWe),
    .perPop(perPop), .perPush(perPush)
  );

  chain_dma_dpath #(.AW(AW), .CNT_W(CNT_W), .LIM_W(LIM_W)) dpath_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .stb(stb), .memRData(memRData), .perRdData(perRdData),
    .memAddr(memAddr), .memWData(memWData), .perWrData(perWrData), .irq(irq),
    .enable(enable), .run(run), .dir(dir), .softRst(softRst),
    .lastWord(lastWord), .remZero(remZero), .remLast(remLast),
    .isLast(isLast), .formatOk(formatOk), .stallHit(stallHit)
  );

endmodule

// File: rtl/chain_dma_chk.sv
module chain_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWrEn,
  input logic [2:0]    regAddr,
  input logic [31:0]   regWrData,
  input logic          memReq,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic          memAck,
  input logic          perPop,
  input logic          perPush,
  input logic          perValid,
  input logic          perReady
);

  logic softWr;
  assign softWr = regWrEn && (regAddr == 3'd0) && regWrData[8];

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !softWr) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R3
  pop_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    perPop |-> (perValid && !memReq && !perPush));

  // R4
  push_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    perPush |-> (perReady && !memReq));

  // R12
  softrst_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    softWr |=> (!memReq && !perPop && !perPush));

endmodule

bind chain_dma chain_dma_chk #(.AW(AW)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memAck(memAck),
  .perPop(perPop), .perPush(perPush), .perValid(perValid), .perReady(perReady)
);

// File: tb/chain_dma_tb.sv
`timescale 1ns/1ps
module chain_dma_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [2:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic        memReq, memWe, memAck, memErr;
  logic [31:0] memAddr, memWData, memRData;
  logic        perValid, perPop, perReady, perPush, perEnd;
  logic [31:0] perRdData, perWrData;
  logic        irq;

  always #2 clk = ~clk;

  chain_dma dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memAck(memAck), .memErr(memErr), .memRData(memRData),
    .perValid(perValid), .perRdData(perRdData), .perPop(perPop),
    .perReady(perReady), .perPush(perPush), .perWrData(perWrData),
    .perEnd(perEnd), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] memArr   [0:1023];
  logic [31:0] srcWords [0:255];
  logic [31:0] sinkWords[0:255];
  int          descCnt  [0:7];
  int          srcIdx, sinkCnt;
  bit          srcEnable, sinkEnable, errOn, reqSeen;
  logic [31:0] errAddr;

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int wordsOf(input int c);
    return (c + 3) / 4;
  endfunction

  // memory and FIFO models
  initial begin
    memAck = 0; memErr = 0; memRData = '0;
    perValid = 0; perReady = 0; perRdData = '0;
    forever begin
      @(negedge clk);
      memAck = 0; memErr = 0;
      if (rstN && memReq) begin
        reqSeen = 1;
        if ($urandom % 4 != 0) begin
          memAck = 1;
          if (errOn && memAddr == errAddr) memErr = 1;
          else if (memWe) memArr[memAddr[11:2]] = memWData;
          else memRData = memArr[memAddr[11:2]];
        end
      end
      perValid  = srcEnable && ($urandom % 3 != 0);
      perRdData = srcWords[srcIdx];
      perReady  = sinkEnable && ($urandom % 3 != 0);
      #1;
      if (perPop) srcIdx++;
      if (perPush) begin
        sinkWords[sinkCnt] = perWrData;
        sinkCnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wrReg(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = idx; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdReg(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    regAddr = idx;
    #1;
    d = regRdData;
  endtask

  task automatic putDesc(input int a, input int cnt, input int bufA, input int br,
                         input bit last, input bit fmt);
    memArr[a/4]     = {last, fmt, 14'd0, 16'(cnt)};
    memArr[a/4 + 1] = 32'(bufA);
    memArr[a/4 + 2] = 32'(br);
    memArr[a/4 + 3] = 32'h0;
  endtask

  task automatic launch(input int dptr, input bit p2m, input int lim);
    wrReg(3'd2, 32'd1);
    wrReg(3'd3, 32'(dptr));
    wrReg(3'd1, 32'd1);
    wrReg(3'd0, 32'd1 | (32'(lim) << 16));
    wrReg(3'd4, (32'd1 << 7) | (32'(p2m) << 22));
  endtask

  task automatic waitIdle(output logic [31:0] chan);
    for (int i = 0; i < 5000; i++) begin
      rdReg(3'd4, chan);
      if (!chan[7]) break;
    end
  endtask

  task automatic randomChain(input bit p2m);
    int n, total, k, bad;
    logic [31:0] chan, v;
    n = 1 + int'($urandom % 4);
    total = 0; k = 0; bad = 0;
    for (int i = 0; i < n; i++) begin
      descCnt[i] = int'($urandom % 17);
      total += wordsOf(descCnt[i]);
      putDesc(32'h100 + 16*i, descCnt[i], 32'h400 + 32'h40*i, 32'h100 + 16*(i+1), i == n-1, 1'b1);
      for (int j = 0; j < 16; j++) memArr[(32'h400 + 32'h40*i)/4 + j] = p2m ? 32'h0 : $urandom;
    end
    for (int i = 0; i < 64; i++) srcWords[i] = $urandom;
    srcIdx = 0; sinkCnt = 0; srcEnable = 1; sinkEnable = 1;
    launch(32'h100, p2m, 20);
    waitIdle(chan);
    checkEq("R5 completion code", 32'(chan[3:0]), 32'd15);
    checkEq("R5 run cleared", 32'(chan[7]), 32'd0);
    rdReg(3'd2, v);
    checkEq("R5 status set", v, 32'd1);
    for (int i = 0; i < n; i++)
      for (int j = 0; j < wordsOf(descCnt[i]); j++) begin
        if (p2m) begin
          if (memArr[(32'h400 + 32'h40*i)/4 + j] !== srcWords[k]) bad++;
        end else begin
          if (sinkWords[k] !== memArr[(32'h400 + 32'h40*i)/4 + j]) bad++;
        end
        k++;
      end
    if (p2m) begin
      checkEq("R3 words popped", 32'(srcIdx), 32'(total));
      checkEq("R3 R2 R6 buffer contents", 32'(bad), 32'd0);
    end else begin
      checkEq("R4 words pushed", 32'(sinkCnt), 32'(total));
      checkEq("R4 R2 R6 pushed contents", 32'(bad), 32'd0);
    end
  endtask

  initial begin
    logic [31:0] v, chan;
    v = $urandom(32'd7719);
    regWrEn = 0; regAddr = '0; regWrData = '0; perEnd = 0;
    srcEnable = 0; sinkEnable = 0; errOn = 0; errAddr = '0; reqSeen = 0;
    srcIdx = 0; sinkCnt = 0;
    for (int i = 0; i < 1024; i++) memArr[i] = '0;
    for (int i = 0; i < 256; i++) begin srcWords[i] = '0; sinkWords[i] = '0; end
    rstN = 0;
    repeat (5) @(negedge clk);
    rstN = 1;

    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      rdReg(3'(i), v);
      checkEq("R1 register reset", v, 32'd0);
    end
    checkEq("R1 irq low", 32'(irq), 32'd0);
    checkEq("R1 no request", 32'(memReq), 32'd0);

    // random chains, both directions
    for (int it = 0; it < 5; it++) begin
      randomChain(1'b1);
      randomChain(1'b0);
    end

    // R6 directed zero-count middle descriptor
    putDesc(32'h100, 8, 32'h400, 32'h110, 0, 1);
    putDesc(32'h110, 0, 32'h440, 32'h120, 0, 1);
    putDesc(32'h120, 5, 32'h480, 32'h130, 1, 1);
    for (int i = 0; i < 8; i++) srcWords[i] = 32'hA000 + 32'(i);
    srcIdx = 0; srcEnable = 1;
    launch(32'h100, 1'b1, 20);
    waitIdle(chan);
    checkEq("R6 zero count success", 32'(chan[3:0]), 32'd15);
    checkEq("R6 zero count words", 32'(srcIdx), 32'd4);
    checkEq("R6 third desc word", memArr[32'h480/4], 32'hA002);

    // R7 underrun
    putDesc(32'h100, 8, 32'h400, 32'h110, 1, 1);
    srcEnable = 0; srcIdx = 0;
    launch(32'h100, 1'b1, 5);
    waitIdle(chan);
    checkEq("R7 underrun code", 32'(chan[3:0]), 32'd1);
    rdReg(3'd2, v);
    checkEq("R7 underrun status", v, 32'd1);

    // R7 overrun
    sinkEnable = 0; sinkCnt = 0;
    launch(32'h100, 1'b0, 5);
    waitIdle(chan);
    checkEq("R7 overrun code", 32'(chan[3:0]), 32'd2);
    checkEq("R7 overrun nothing pushed", 32'(sinkCnt), 32'd0);
    sinkEnable = 1;

    // R8 fetch error on second descriptor
    putDesc(32'h100, 4, 32'h400, 32'h110, 0, 1);
    putDesc(32'h110, 4, 32'h440, 32'h120, 1, 1);
    srcEnable = 1; srcIdx = 0; errOn = 1; errAddr = 32'h118;
    launch(32'h100, 1'b1, 20);
    waitIdle(chan);
    checkEq("R8 fetch error code", 32'(chan[3:0]), 32'd3);
    checkEq("R8 first desc moved only", 32'(srcIdx), 32'd1);
    errOn = 0;

    // R8 format bit clear
    putDesc(32'h100, 8, 32'h400, 32'h110, 1, 0);
    srcIdx = 0;
    launch(32'h100, 1'b1, 20);
    waitIdle(chan);
    checkEq("R8 format code", 32'(chan[3:0]), 32'd3);
    checkEq("R8 format no data", 32'(srcIdx), 32'd0);

    // R9 data error on second beat
    putDesc(32'h100, 12, 32'h400, 32'h110, 1, 1);
    sinkCnt = 0; errOn = 1; errAddr = 32'h404;
    launch(32'h100, 1'b0, 20);
    waitIdle(chan);
    checkEq("R9 data error code", 32'(chan[3:0]), 32'd4);
    checkEq("R9 one word pushed", 32'(sinkCnt), 32'd1);
    errOn = 0;

    // R10 early end
    srcEnable = 0; perEnd = 1;
    launch(32'h100, 1'b1, 20);
    waitIdle(chan);
    checkEq("R10 early end code", 32'(chan[3:0]), 32'd5);
    perEnd = 0; srcEnable = 1;

    // R11 interrupt gating and clear
    wrReg(3'd1, 32'd0);
    #1 checkEq("R11 irq masked", 32'(irq), 32'd0);
    wrReg(3'd1, 32'd1);
    #1 checkEq("R11 irq unmasked", 32'(irq), 32'd1);
    wrReg(3'd2, 32'd0);
    rdReg(3'd2, v);
    checkEq("R11 write zero keeps status", v, 32'd1);
    wrReg(3'd2, 32'd1);
    rdReg(3'd2, v);
    checkEq("R11 status cleared", v, 32'd0);
    checkEq("R11 irq dropped", 32'(irq), 32'd0);

    // R12 soft reset mid walk
    srcEnable = 0;
    launch(32'h100, 1'b1, 255);
    repeat (20) @(negedge clk);
    wrReg(3'd0, 32'h100);
    rdReg(3'd0, v);
    checkEq("R12 enable cleared", 32'(v[0]), 32'd0);
    rdReg(3'd4, v);
    checkEq("R12 run cleared", 32'(v[7]), 32'd0);
    reqSeen = 0;
    srcEnable = 1;
    repeat (10) @(negedge clk);
    checkEq("R12 no request after reset", 32'(reqSeen), 32'd0);

    // R13 run without enable
    putDesc(32'h100, 4, 32'h400, 32'h110, 1, 1);
    srcIdx = 0;
    wrReg(3'd2, 32'd1);
    wrReg(3'd3, 32'h100);
    wrReg(3'd0, 32'd20 << 16);
    wrReg(3'd4, (32'd1 << 7) | (32'd1 << 22));
    reqSeen = 0;
    repeat (10) @(negedge clk);
    checkEq("R13 idle while disabled", 32'(reqSeen), 32'd0);
    rdReg(3'd4, v);
    checkEq("R13 run still set", 32'(v[7]), 32'd1);
    wrReg(3'd0, 32'd1 | (32'd20 << 16));
    waitIdle(chan);
    checkEq("R13 completes once enabled", 32'(chan[3:0]), 32'd15);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule